// File: doc/BRIEF.md
# Segregated Free-List Frame Allocator

This block hands out and takes back fixed-size frames kept on per-class linked lists in memory. A table in memory, starting at the address on `tbl_base`, holds one list head per size class. An allocate command names a class and receives the first frame of that list, or a frame fault. A free command names a frame. The block reads the frame's class from the word just below it and pushes the frame onto the front of that class's list.

A head word carries a 2-bit tag in its low bits. Tag 0 marks a frame pointer. Tag 1 marks an empty list. Tags 2 and 3 redirect the request to another class, whose number sits in the bits above the tag. The allocator then repeats the lookup, up to a fixed number of hops. Before a frame is returned it is written once, so that any write-protect fault on it is raised before the caller owns it.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the block is idle, and a command transfers on a cycle where both `cmd_valid` and `cmd_ready` are high. Memory requests use a valid/ready pair. Once raised, `mem_valid` holds its address, direction and write data until `mem_ready` accepts them. Read data returns later with a one-cycle `mem_rvalid` strobe, and only one read is outstanding at a time. Completion is reported on plain one-cycle strobes.

Top module: `frame_alloc`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. After a command is accepted, `busy` is high from the next cycle until the cycle in which `done` or `fault` pulses, and in that cycle `busy` is low.
- R2: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle. A read's data is taken from `mem_rdata` in the cycle `mem_rvalid` is high.
- R3: An allocate (`cmd_free`=0) reads the head word at `tbl_base + fsi`, where fsi is `cmd_arg[FSW-1:0]`. If the head word's low 2 bits are 0, the command ends with `done` and `result` equal to that head word.
- R4: On a tag-0 head, the allocator reads word 0 of the frame (the next link). It then writes that value back to frame word 0, and after that writes it to the head entry. These are exactly two writes, in that order, both before `done`.
- R5: A head word with tag 1 (empty) ends the allocate with `fault`, with `fault_fsi` equal to the fsi originally requested, even after redirects. No memory write is made.
- R6: A head word with tag 2 or 3 (redirect) restarts the lookup at class `head[FSW+1:2]`. It uses the same table base and still follows R3 to R5.
- R7: An allocate follows at most MAX_HOPS redirects. A further redirect ends it with `fault`, with `fault_fsi` equal to the original fsi and no memory write.
- R8: A free (`cmd_free`=1) of frame F = `cmd_arg` reads word F-1 and takes its low FSW bits as the class c. It reads the head H at `tbl_base + c`, writes F to that head entry, then writes H to word F. It ends with `done` and `result` = F.
- R9: After reset the block is idle with `done`, `fault` and `mem_valid` low. `done` and `fault` are single-cycle pulses and never high together.
- R10: No memory request is issued while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | AW | Address of the list-head table |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_free | input | 1 | 0 = allocate, 1 = free |
| cmd_arg | input | AW | Size class (low FSW bits) for allocate, frame pointer for free |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| result | output | AW | Allocated or freed frame, valid with `done` |
| fault | output | 1 | One-cycle pulse: frame fault |
| fault_fsi | output | FSW | Originally requested class, valid with `fault` |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | AW | Write data |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | AW | Read data |

## Verification
The embedded properties watch, on every cycle, the memory request holding steady under back-pressure, the silence of the memory port while idle, the exclusivity and timing of the completion strobes, and the bound on the hop counter. The order and values of the two writes per operation, the class arithmetic on redirects (including truncation to FSW bits), the exact hop count at which the fault appears, and the fault's report of the original class all depend on memory contents. Only the bench's scenarios can show these. It sweeps every class through allocate, exhaustion and free, and sweeps redirect chains from zero to one beyond the cap, with random memory stalls.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_A_HEAD,
    S_A_NEXT,
    S_A_DIRTY,
    S_A_SETHEAD,
    S_F_SIZE,
    S_F_HEAD,
    S_F_SETHEAD,
    S_F_LINK
  } fa_state_t;

  typedef enum logic [1:0] {
    HK_FRAME,
    HK_EMPTY,
    HK_REDIRECT
  } head_kind_t;

  localparam logic [1:0] TAG_FRAME = 2'd0;
  localparam logic [1:0] TAG_EMPTY = 2'd1;
endpackage

// File: rtl/fa_tag_decode.sv
module fa_tag_decode
  import fa_pkg::*;
#(
  parameter int AW  = 16,
  parameter int FSW = 8
) (
  input  logic [AW-1:0]  word,
  output head_kind_t     kind,
  output logic [FSW-1:0] target
);
  always_comb begin
    unique case (word[1:0])
      TAG_FRAME: kind = HK_FRAME;
      TAG_EMPTY: kind = HK_EMPTY;
      default:   kind = HK_REDIRECT;
    endcase
  end

  assign target = word[FSW+1:2];
endmodule

// File: rtl/fa_hop_limit.sv
module fa_hop_limit #(
  parameter int MAX_HOPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(MAX_HOPS));

  // R7
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CW'(MAX_HOPS)));
endmodule

// File: rtl/frame_alloc.sv
module frame_alloc
  import fa_pkg::*;
#(
  parameter int AW       = 16,
  parameter int FSW      = 8,
  parameter int MAX_HOPS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  tbl_base,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_free,
  input  logic [AW-1:0]  cmd_arg,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  result,
  output logic           fault,
  output logic [FSW-1:0] fault_fsi,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [AW-1:0]  mem_rdata
);
  localparam int PADW = AW - FSW;

  fa_state_t      state;
  logic           waiting;
  logic [FSW-1:0] fsi_cur, fsi_orig;
  logic [AW-1:0]  frame_q, link_q, head_addr;
  head_kind_t     kind;
  logic [FSW-1:0] redirect_fsi;
  logic           is_read, is_write, take, rd_back;
  logic           hop_clr, hop_step, hop_full;

  fa_tag_decode #(.AW(AW), .FSW(FSW)) u_dec (
    .word(mem_rdata), .kind(kind), .target(redirect_fsi)
  );

  fa_hop_limit #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst_n(rst_n), .clear(hop_clr), .step(hop_step), .at_limit(hop_full)
  );

  assign head_addr = tbl_base + {{PADW{1'b0}}, fsi_cur};

  always_comb begin
    is_read   = 1'b0;
    is_write  = 1'b0;
    mem_addr  = frame_q;
    mem_wdata = link_q;
    unique case (state)
      S_A_HEAD:    begin is_read  = 1'b1; mem_addr = head_addr; end
      S_A_NEXT:    begin is_read  = 1'b1; end
      S_A_DIRTY:   begin is_write = 1'b1; end
      S_A_SETHEAD: begin is_write = 1'b1; mem_addr = head_addr; end
      S_F_SIZE:    begin is_read  = 1'b1; mem_addr = frame_q - 1'b1; end
      S_F_HEAD:    begin is_read  = 1'b1; mem_addr = head_addr; end
      S_F_SETHEAD: begin is_write = 1'b1; mem_addr = head_addr; mem_wdata = frame_q; end
      S_F_LINK:    begin is_write = 1'b1; end
      default:     ;
    endcase
  end

  assign mem_valid = (is_read && !waiting) || is_write;
  assign mem_we    = is_write;
  assign take      = mem_valid && mem_ready;
  assign rd_back   = waiting && mem_rvalid;
  assign busy      = (state != S_IDLE);
  assign cmd_ready = (state == S_IDLE);
  assign hop_clr   = cmd_valid && cmd_ready;
  assign hop_step  = rd_back && (state == S_A_HEAD) && (kind == HK_REDIRECT) && !hop_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      waiting   <= 1'b0;
      fsi_cur   <= '0;
      fsi_orig  <= '0;
      frame_q   <= '0;
      link_q    <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      result    <= '0;
      fault_fsi <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (is_read && take) waiting <= 1'b1;
      if (rd_back)         waiting <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          if (cmd_free) begin
            frame_q <= cmd_arg;
            state   <= S_F_SIZE;
          end else begin
            fsi_cur  <= cmd_arg[FSW-1:0];
            fsi_orig <= cmd_arg[FSW-1:0];
            state    <= S_A_HEAD;
          end
        end
        S_A_HEAD: if (rd_back) begin
          unique case (kind)
            HK_FRAME: begin frame_q <= mem_rdata; state <= S_A_NEXT; end
            HK_EMPTY: begin fault <= 1'b1; fault_fsi <= fsi_orig; state <= S_IDLE; end
            default: begin
              if (hop_full) begin
                fault <= 1'b1; fault_fsi <= fsi_orig; state <= S_IDLE;
              end else begin
                fsi_cur <= redirect_fsi;
              end
            end
          endcase
        end
        S_A_NEXT:    if (rd_back) begin link_q <= mem_rdata; state <= S_A_DIRTY; end
        S_A_DIRTY:   if (take) state <= S_A_SETHEAD;
        S_A_SETHEAD: if (take) begin done <= 1'b1; result <= frame_q; state <= S_IDLE; end
        S_F_SIZE:    if (rd_back) begin fsi_cur <= mem_rdata[FSW-1:0]; state <= S_F_HEAD; end
        S_F_HEAD:    if (rd_back) begin link_q <= mem_rdata; state <= S_F_SETHEAD; end
        S_F_SETHEAD: if (take) state <= S_F_LINK;
        S_F_LINK:    if (take) begin done <= 1'b1; result <= frame_q; state <= S_IDLE; end
        default:     state <= S_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R1
  end_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> ($past(busy) && !busy));
endmodule

// File: tb/test_frame_alloc.sv
`timescale 1ns/1ps
module test_frame_alloc;
  localparam int AW = 10;
  localparam int FSW = 3;
  localparam int MAXH = 4;
  localparam logic [AW-1:0] TBL = 10'h020;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_free = 1'b0;
  logic [AW-1:0] cmd_arg = '0;
  logic cmd_ready, busy, done, fault, mem_valid, mem_we;
  logic [AW-1:0] result, mem_addr, mem_wdata;
  logic [FSW-1:0] fault_fsi;
  logic mem_rvalid;
  logic [AW-1:0] mem_rdata;
  logic mem_ready;

  always #2.5 clk = ~clk;

  frame_alloc #(.AW(AW), .FSW(FSW), .MAX_HOPS(MAXH)) i_frame_alloc (
    .clk(clk), .rst_n(rst_n), .tbl_base(TBL),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_free(cmd_free), .cmd_arg(cmd_arg),
    .busy(busy), .done(done), .result(result), .fault(fault), .fault_fsi(fault_fsi),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model with random stalls and a write log
  logic [AW-1:0] mem [0:1023];
  logic [AW-1:0] wl_a [0:255];
  logic [AW-1:0] wl_d [0:255];
  int wcnt;
  logic [7:0] lfsr;
  logic stall_en = 1'b0;
  logic pk_en = 1'b0;
  logic [AW-1:0] pk_a = '0, pk_d = '0;

  assign mem_ready = !stall_en || lfsr[0];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      wcnt       <= 0;
      lfsr       <= 8'hA5;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rvalid <= 1'b0;
      if (pk_en) mem[pk_a] <= pk_d;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wl_a[wcnt[7:0]] <= mem_addr;
          wl_d[wcnt[7:0]] <= mem_wdata;
          wcnt <= wcnt + 1;
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr];
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  bit r_done, r_fault;
  logic [AW-1:0] r_res;
  logic [FSW-1:0] r_ffsi;
  int w0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [AW-1:0] d);
    @(negedge clk); pk_en = 1'b1; pk_a = a; pk_d = d;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic run_op(input bit is_free, input logic [AW-1:0] arg);
    int n;
    @(negedge clk);
    w0 = wcnt;
    chk(cmd_ready == 1'b1, "R1 ready when idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_free = is_free; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R1 busy after accept", int'(busy), 1);
    n = 0;
    while (!(done || fault) && n < 500) begin @(negedge clk); n++; end
    r_done = done; r_fault = fault; r_res = result; r_ffsi = fault_fsi;
    chk(!busy && cmd_ready, "R1 idle at completion", int'(busy), 0);
    @(negedge clk);
    chk(!done && !fault, "R9 strobes single cycle", int'(done | fault), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_valid && cmd_ready, "R9 reset state",
        int'({busy, done, fault, mem_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_valid, "R10 no request when idle", int'(mem_valid), 0);

    // per-class sweep: two frames each, allocate to exhaustion, free back
    for (int c = 0; c < 8; c++) begin
      logic [AW-1:0] fa, fb;
      fa = AW'(10'h100 + c * 32);
      fb = fa + AW'(16);
      stall_en = c[0];
      poke(fa - 1'b1, AW'(c)); poke(fb - 1'b1, AW'(c));
      poke(fa, fb); poke(fb, AW'(1));
      poke(TBL + AW'(c), fa);

      run_op(1'b0, AW'(c));
      chk(r_done && r_res == fa, "R3 first frame", int'(r_res), int'(fa));
      chk(mem[TBL + AW'(c)] == fb, "R4 head advanced", int'(mem[TBL + AW'(c)]), int'(fb));
      chk(wcnt - w0 == 2, "R4 two writes", wcnt - w0, 2);
      chk(wl_a[w0[7:0]] == fa && wl_d[w0[7:0]] == fb, "R4 frame written first",
          int'(wl_a[w0[7:0]]), int'(fa));
      chk(wl_a[w0[7:0] + 8'd1] == TBL + AW'(c), "R4 head written second",
          int'(wl_a[w0[7:0] + 8'd1]), int'(TBL + AW'(c)));

      run_op(1'b0, AW'(c));
      chk(r_done && r_res == fb, "R3 second frame", int'(r_res), int'(fb));
      chk(mem[TBL + AW'(c)] == AW'(1), "R4 head now empty", int'(mem[TBL + AW'(c)]), 1);

      run_op(1'b0, AW'(c));
      chk(r_fault && !r_done, "R5 empty faults", int'(r_fault), 1);
      chk(r_ffsi == FSW'(c), "R5 fault class", int'(r_ffsi), c);
      chk(wcnt == w0, "R5 no writes", wcnt - w0, 0);

      run_op(1'b1, fa);
      chk(r_done && r_res == fa, "R8 free result", int'(r_res), int'(fa));
      chk(mem[TBL + AW'(c)] == fa && mem[fa] == AW'(1), "R8 pushed on empty",
          int'(mem[fa]), 1);
      chk(wcnt - w0 == 2 && wl_a[w0[7:0]] == TBL + AW'(c), "R8 head written first",
          int'(wl_a[w0[7:0]]), int'(TBL + AW'(c)));

      run_op(1'b1, fb);
      chk(mem[TBL + AW'(c)] == fb && mem[fb] == fa, "R8 old head linked",
          int'(mem[fb]), int'(fa));
    end

    // redirect chain sweep from class 0, 0..MAXH+1 hops
    for (int h = 0; h <= MAXH + 1; h++) begin
      logic [AW-1:0] ff;
      ff = AW'(10'h300);
      stall_en = h[0];
      for (int k = 0; k < h; k++)
        poke(TBL + AW'(k), AW'(((k + 1) << 2) | ((k % 2 == 1) ? 3 : 2)));
      poke(TBL + AW'(h), ff);
      poke(ff, AW'(1));
      run_op(1'b0, AW'(0));
      if (h <= MAXH) begin
        chk(r_done && r_res == ff, "R6 redirect reaches frame", int'(r_res), int'(ff));
        chk(mem[TBL + AW'(h)] == AW'(1), "R6 target head updated", int'(mem[TBL + AW'(h)]), 1);
      end else begin
        chk(r_fault && r_ffsi == '0, "R7 hop cap faults", int'(r_fault), 1);
        chk(wcnt == w0, "R7 no writes", wcnt - w0, 0);
      end
    end

    // redirect into an empty class reports the original class
    stall_en = 1'b1;
    poke(TBL + AW'(2), AW'((5 << 2) | 2));
    poke(TBL + AW'(5), AW'(1));
    run_op(1'b0, AW'(2));
    chk(r_fault && r_ffsi == FSW'(2), "R5 original class after redirect", int'(r_ffsi), 2);

    // redirect target truncated to FSW bits: 9 -> 1, a self loop hitting the cap
    poke(TBL + AW'(1), AW'((9 << 2) | 2));
    run_op(1'b0, AW'(1));
    chk(r_fault && r_ffsi == FSW'(1), "R6 R7 truncated self redirect", int'(r_ffsi), 1);
    chk(wcnt == w0, "R7 no writes on loop", wcnt - w0, 0);

    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!mem_valid && !busy, "R10 quiet after run", int'(mem_valid), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule